// File: doc/BRIEF.md
# Flash Protection Setup Sequencer

This block runs once after every reset. It puts an attached serial NOR flash into one fixed protection state. In that state the protected area is anchored at the low end of the array, quad I/O is enabled, and only the smallest block-protect level is active.

The block does not drive the SPI wires itself. It sends high-level command requests to a downstream command engine and receives the read bytes back from it. The block reads a register, decides, and writes only when a write is needed. A one-time-programmable bit is never written a second time. After each non-volatile write, the block polls the flash busy flag.

When the sequence finishes, the block raises `seqDone`. If a busy poll runs too long, it raises `seqError` and stops. In both cases the outputs hold until the next reset.

Top module: `flash_protect_seq`

## Requirements
- R1: While reset is asserted, `seqDone` and `seqError` are low. The first command issued after reset is read-function (code 1, length 1).
- R2: Command codes are: 1 read-function, 2 write-enable, 3 write-function, 4 read-status, 5 write-status. A write-enable (length 0) directly precedes every write command.
- R3: The function-register bit at position 3 selects bottom anchoring. If the first read returns this bit clear, the block issues write-enable and then write-function with the byte 0x08 (length 1).
- R4: The bit at position 3 is one-time-programmable. If it reads as set, no write-function command is issued.
- R5: After the function step, the block issues read-status repeatedly while bit 0 (busy) of the returned byte is 1.
- R6: The status bits checked are bit 2 to bit 5 (protect levels 0 to 3) and bit 6 (quad enable). The target is bit 6 = 1, bit 2 = 1, and bits 3 to 5 = 0. If the last read matches, no status write is issued and `seqDone` rises.
- R7: On a mismatch, the block issues write-enable and then write-status with one byte. That byte is the last read value with bit 2 and bit 6 set, bits 3 to 5 cleared, and bits 0, 1 and 7 unchanged.
- R8: After a status write, the block polls read-status until bit 0 is clear before it raises `seqDone`.
- R9: Each request holds its code, length and write byte stable until `cmdAck`. Read data counts only in the cycle where `cmdAck` is high.
- R10: If `MAX_POLLS` consecutive status reads in one poll phase all return busy, `seqError` rises and no further command is issued.
- R11: `seqDone` and `seqError` never rise together, stay high until reset, and no request is raised after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; restarts the sequence |
| cmdReq | output | 1 | Command request, held until acknowledged |
| cmdCode | output | 3 | Command code (see R2) |
| cmdLen | output | 2 | Number of data bytes in the command |
| cmdWrData | output | 8 | Byte to write for write commands |
| cmdAck | input | 1 | One-cycle completion pulse from the command engine |
| cmdRdData | input | 8 | Read byte, valid with `cmdAck` |
| seqDone | output | 1 | Sequence finished successfully (sticky) |
| seqError | output | 1 | Busy poll limit exceeded (sticky) |

## Verification
The hardest case to reach from the ports is the exact poll-limit edge. The flash must stay busy for exactly `MAX_POLLS - 1` reads in one phase, which passes, or for exactly `MAX_POLLS` reads, which fails. This has to be shown separately after the function write and after the status write.

The bench's flash model sets its busy duration per write and per scenario. Directed cases place the duration on both sides of the limit in each phase. Random cases draw durations that often land near the limit. Stray read bytes are driven outside the acknowledge cycle, so sampling at the wrong time would corrupt the decision.

// File: rtl/flash_protect_pkg.sv
package flash_protect_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_RD_FUNC = 3'd1,
    CMD_WR_EN   = 3'd2,
    CMD_WR_FUNC = 3'd3,
    CMD_RD_STAT = 3'd4,
    CMD_WR_STAT = 3'd5
  } cmd_e;

  localparam int DATA_W   = 8;
  localparam int LEN_W    = 2;
  localparam int BUSY_BIT = 0;
  localparam int PROT_LO  = 2;
  localparam int PROT_HI  = 5;
  localparam int QUAD_BIT = 6;
  localparam int ANCH_BIT = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic capFunc;     // capture read byte into function copy
    logic capStat;     // capture read byte into status copy, count busy
    logic clrPoll;     // restart poll counter
    logic selStatByte; // write byte: 1 = modified status, 0 = anchor byte
  } dp_strobe_t;

endpackage

// File: rtl/flash_protect_dp.sv
module flash_protect_dp
  import flash_protect_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData,
  output logic              anchorSet,
  output logic              statBusy,
  output logic              statMatch,
  output logic              pollLimit
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam int PROT_N = PROT_HI - PROT_LO + 1;

  logic [DATA_W-1:0] funcCopy;
  logic [DATA_W-1:0] statCopy;
  logic [CNT_W-1:0]  pollCnt;
  logic [DATA_W-1:0] fixedStat;
  logic [DATA_W-1:0] anchorByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcCopy <= '0;
      statCopy <= '0;
      pollCnt  <= '0;
    end else begin
      if (strobe.capFunc) funcCopy <= rdData;
      if (strobe.capStat) statCopy <= rdData;
      if (strobe.clrPoll) begin
        pollCnt <= '0;
      end else if (strobe.capStat && rdData[BUSY_BIT] &&
                   (pollCnt < CNT_W'(MAX_POLLS))) begin
        pollCnt <= pollCnt + 1'b1;
      end
    end
  end

  // status byte with the target protection fields forced, others kept
  always_comb begin
    fixedStat = statCopy;
    for (int i = PROT_LO; i <= PROT_HI; i++) begin
      fixedStat[i] = (i == PROT_LO);
    end
    fixedStat[QUAD_BIT] = 1'b1;
  end

  always_comb begin
    anchorByte = '0;
    anchorByte[ANCH_BIT] = 1'b1;
  end

  assign wrData    = strobe.selStatByte ? fixedStat : anchorByte;
  assign anchorSet = funcCopy[ANCH_BIT];
  assign statBusy  = statCopy[BUSY_BIT];
  assign statMatch = (statCopy[QUAD_BIT] == 1'b1) &&
                     (statCopy[PROT_HI:PROT_LO] == PROT_N'(1));
  assign pollLimit = (pollCnt >= CNT_W'(MAX_POLLS));

endmodule

// File: rtl/flash_protect_ctrl.sv
module flash_protect_ctrl
  import flash_protect_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdAck,
  input  logic             anchorSet,
  input  logic             statBusy,
  input  logic             statMatch,
  input  logic             pollLimit,
  output logic             cmdReq,
  output logic [2:0]       cmdCode,
  output logic [LEN_W-1:0] cmdLen,
  output dp_strobe_t       strobe,
  output logic             seqDone,
  output logic             seqError
);
  typedef enum logic [3:0] {
    S_RD_FUNC, S_EVAL_FUNC, S_WEN_FUNC, S_WR_FUNC,
    S_POLL_A, S_EVAL_A, S_WEN_STAT, S_WR_STAT,
    S_POLL_B, S_EVAL_B, S_DONE, S_ERR
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_RD_FUNC;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmdReq    = 1'b0;
    cmdCode   = CMD_NONE;
    cmdLen    = '0;
    strobe    = '0;
    unique case (state)
      S_RD_FUNC: begin
        cmdReq = 1'b1; cmdCode = CMD_RD_FUNC; cmdLen = LEN_W'(1);
        if (cmdAck) begin
          strobe.capFunc = 1'b1;
          nextState = S_EVAL_FUNC;
        end
      end
      S_EVAL_FUNC: nextState = anchorSet ? S_POLL_A : S_WEN_FUNC;
      S_WEN_FUNC: begin
        cmdReq = 1'b1; cmdCode = CMD_WR_EN;
        if (cmdAck) nextState = S_WR_FUNC;
      end
      S_WR_FUNC: begin
        cmdReq = 1'b1; cmdCode = CMD_WR_FUNC; cmdLen = LEN_W'(1);
        if (cmdAck) begin
          strobe.clrPoll = 1'b1;
          nextState = S_POLL_A;
        end
      end
      S_POLL_A: begin
        cmdReq = 1'b1; cmdCode = CMD_RD_STAT; cmdLen = LEN_W'(1);
        if (cmdAck) begin
          strobe.capStat = 1'b1;
          nextState = S_EVAL_A;
        end
      end
      S_EVAL_A: begin
        if (!statBusy)     nextState = statMatch ? S_DONE : S_WEN_STAT;
        else if (pollLimit) nextState = S_ERR;
        else               nextState = S_POLL_A;
      end
      S_WEN_STAT: begin
        cmdReq = 1'b1; cmdCode = CMD_WR_EN;
        strobe.selStatByte = 1'b1;
        if (cmdAck) nextState = S_WR_STAT;
      end
      S_WR_STAT: begin
        cmdReq = 1'b1; cmdCode = CMD_WR_STAT; cmdLen = LEN_W'(1);
        strobe.selStatByte = 1'b1;
        if (cmdAck) begin
          strobe.clrPoll = 1'b1;
          nextState = S_POLL_B;
        end
      end
      S_POLL_B: begin
        cmdReq = 1'b1; cmdCode = CMD_RD_STAT; cmdLen = LEN_W'(1);
        if (cmdAck) begin
          strobe.capStat = 1'b1;
          nextState = S_EVAL_B;
        end
      end
      S_EVAL_B: begin
        if (!statBusy)      nextState = S_DONE;
        else if (pollLimit) nextState = S_ERR;
        else                nextState = S_POLL_B;
      end
      S_DONE:  nextState = S_DONE;
      S_ERR:   nextState = S_ERR;
      default: nextState = S_ERR;
    endcase
  end

  assign seqDone  = (state == S_DONE);
  assign seqError = (state == S_ERR);

endmodule

// File: rtl/flash_protect_seq.sv
module flash_protect_seq
  import flash_protect_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       cmdReq,
  output logic [2:0] cmdCode,
  output logic [1:0] cmdLen,
  output logic [7:0] cmdWrData,
  input  logic       cmdAck,
  input  logic [7:0] cmdRdData,
  output logic       seqDone,
  output logic       seqError
);
  dp_strobe_t strobe;
  logic anchorSet, statBusy, statMatch, pollLimit;

  flash_protect_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdAck(cmdAck),
    .anchorSet(anchorSet), .statBusy(statBusy),
    .statMatch(statMatch), .pollLimit(pollLimit),
    .cmdReq(cmdReq), .cmdCode(cmdCode), .cmdLen(cmdLen),
    .strobe(strobe), .seqDone(seqDone), .seqError(seqError)
  );

  flash_protect_dp #(.MAX_POLLS(MAX_POLLS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(cmdRdData),
    .wrData(cmdWrData), .anchorSet(anchorSet), .statBusy(statBusy),
    .statMatch(statMatch), .pollLimit(pollLimit)
  );

endmodule

// File: rtl/flash_protect_seq_chk.sv
module flash_protect_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReq,
  input logic [2:0] cmdCode,
  input logic [1:0] cmdLen,
  input logic [7:0] cmdWrData,
  input logic       cmdAck,
  input logic       seqDone,
  input logic       seqError
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdAck) |=> (cmdReq && $stable(cmdCode) &&
                             $stable(cmdLen) && $stable(cmdWrData)));

  assert_anchor_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdCode == 3'd3) |-> (cmdWrData == 8'h08 && cmdLen == 2'd1));

  assert_stat_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdCode == 3'd5) |-> ((cmdWrData & 8'h7C) == 8'h44));

  assert_wen_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdCode == 3'd2) |-> (cmdLen == 2'd0));

  assert_quiet_end_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone || seqError) |-> !cmdReq);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && seqError));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> seqDone);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError);
endmodule

bind flash_protect_seq flash_protect_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdCode(cmdCode),
  .cmdLen(cmdLen), .cmdWrData(cmdWrData), .cmdAck(cmdAck),
  .seqDone(seqDone), .seqError(seqError)
);

// File: tb/tb_flash_protect_seq.sv
module tb_flash_protect_seq;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdReq;
  logic [2:0] cmdCode;
  logic [1:0] cmdLen;
  logic [7:0] cmdWrData;
  logic cmdAck = 1'b0;
  logic [7:0] cmdRdData = 8'h00;
  logic seqDone, seqError;

  always #10 clk = ~clk;

  flash_protect_seq #(.MAX_POLLS(MAXP)) dut (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdCode(cmdCode),
    .cmdLen(cmdLen), .cmdWrData(cmdWrData), .cmdAck(cmdAck),
    .cmdRdData(cmdRdData), .seqDone(seqDone), .seqError(seqError)
  );

  int checks = 0, errors = 0;
  // flash model state
  logic [7:0] funcM, statM, lastWr;
  int busyLeft, busyA, busyB;
  bit wenM;
  int cmdCount, funcWrites, statWrites, wenViol, lenBad, firstCode;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // command engine + flash model; read byte valid only with ack
  initial begin
    forever begin
      @(negedge clk);
      cmdAck = 1'b0;
      cmdRdData = 8'($urandom);
      if (rstN && cmdReq) begin
        logic [2:0] code;
        code = cmdCode;
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          cmdRdData = 8'($urandom);
        end
        if (cmdCount == 0) firstCode = code;
        cmdCount++;
        if ((code == 3'd2) != (cmdLen == 2'd0)) lenBad++;
        case (code)
          3'd1: cmdRdData = funcM;
          3'd2: wenM = 1'b1;
          3'd3: begin
            if (!wenM) wenViol++;
            funcM = funcM | cmdWrData; funcWrites++; wenM = 1'b0; busyLeft = busyA;
          end
          3'd4: begin
            cmdRdData = statM | 8'(busyLeft > 0);
            if (busyLeft > 0) busyLeft--;
          end
          3'd5: begin
            if (!wenM) wenViol++;
            statM = cmdWrData & 8'hFE; lastWr = cmdWrData; statWrites++;
            wenM = 1'b0; busyLeft = busyB;
          end
          default: wenViol++;
        endcase
        cmdAck = 1'b1;
      end
    end
  end

  function automatic logic [7:0] fixByte(input logic [7:0] s);
    logic [7:0] e;
    e = s;
    e[6] = 1'b1; e[2] = 1'b1; e[3] = 1'b0; e[4] = 1'b0; e[5] = 1'b0;
    return e;
  endfunction

  task automatic runCase(input logic [7:0] f, input logic [7:0] s, input int bA, input int bB);
    int expCount, reads;
    bit expErr, expFuncW, expStatW, match;
    logic [7:0] expByte;
    int cntAtEnd;
    rstN = 1'b0;
    funcM = f; statM = s & 8'hFE; busyLeft = bA; busyA = bA; busyB = bB;
    wenM = 1'b0; lastWr = 8'h00;
    cmdCount = 0; funcWrites = 0; statWrites = 0; wenViol = 0; lenBad = 0; firstCode = 0;
    repeat (3) @(negedge clk);
    check(!seqDone && !seqError, "R1 reset outputs", {seqDone, seqError}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 3000 && !(seqDone || seqError); i++) @(negedge clk);
    cntAtEnd = cmdCount;
    repeat (20) @(negedge clk);

    // expected behaviour from the requirements
    expFuncW = !f[3];
    expErr = (bA >= MAXP);
    reads = expErr ? MAXP : bA + 1;
    expCount = 1 + (expFuncW ? 2 : 0) + reads;
    expStatW = 1'b0;
    expByte = 8'h00;
    if (!expErr) begin
      match = (s[6] == 1'b1) && (s[5:2] == 4'b0001);
      expStatW = !match;
      if (expStatW) begin
        expByte = fixByte(s & 8'hFE);
        expErr = (bB >= MAXP);
        expCount += 2 + (expErr ? MAXP : bB + 1);
      end
    end

    check(firstCode == 1, "R1 first command", firstCode, 1);
    check(funcWrites == int'(expFuncW), "R3/R4 function writes", funcWrites, int'(expFuncW));
    check(funcM[3] == 1'b1, "R3 anchor bit", funcM, 8);
    check(wenViol == 0, "R2 write-enable order", wenViol, 0);
    check(lenBad == 0, "R9 length", lenBad, 0);
    check(statWrites == int'(expStatW), "R6/R7 status writes", statWrites, int'(expStatW));
    if (expStatW) check(lastWr == expByte, "R7 status byte", lastWr, expByte);
    check(cmdCount == expCount, "R5/R8/R10 command count", cmdCount, expCount);
    check(seqError == expErr, "R10 error", seqError, expErr);
    check(seqDone == !expErr, "R6/R8 done", seqDone, !expErr);
    check(cmdCount == cntAtEnd && !cmdReq, "R11 quiet after end", cmdCount, cntAtEnd);
  endtask

  initial begin
    int seedv;
    seedv = $urandom(32'd5150);
    repeat (2) @(negedge clk);
    runCase(8'h08, 8'h44, 0, 0);          // already configured: no writes
    runCase(8'h00, 8'h00, 3, 2);          // both writes
    runCase(8'h08, 8'hBE, 1, 4);          // keep bits 1 and 7, fix rest
    runCase(8'h00, 8'h44, MAXP, 0);       // error in first poll phase
    runCase(8'h08, 8'h44, MAXP - 1, 0);   // just below limit, phase one
    runCase(8'h08, 8'h00, 0, MAXP);       // error in second poll phase
    runCase(8'h00, 8'h20, 2, MAXP - 1);   // just below limit, phase two
    runCase(8'hF7, 8'h46, 0, 0);          // other function bits, status match with WEL
    for (int k = 0; k < 28; k++) begin
      logic [7:0] f, s;
      int a, b;
      f = 8'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 8'($urandom) | 8'h44 & 8'hC7 : 8'($urandom);
      a = $urandom_range(0, 2) == 0 ? $urandom_range(MAXP - 2, MAXP + 1) : $urandom_range(0, 5);
      b = $urandom_range(0, 2) == 0 ? $urandom_range(MAXP - 2, MAXP + 1) : $urandom_range(0, 5);
      runCase(f, s, a, b);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule